// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus and a B bus through a set of independent lanes, each one byte wide by default. Each lane either keeps both buses apart, or drives one of them from the other. The value it drives can be the live value on the other bus or a copy held in a capture register. Every lane has one capture register per side. A rising edge on the lane's A-side or B-side capture strobe loads it. Loading happens in every mode, including while the lane drives nothing.

Each bidirectional pin is split into four signals: an input value, a flag that says whether something outside drives the pin, an output value, and a per-bit output enable. The block also exports a resolved view of each bus. While a bus is driven from inside or outside, the view shows that value. While nothing drives it, a keeper register supplies the last driven value, so an idle bus never floats.

Everything runs on one free-running system clock. The capture strobes are sampled as ordinary synchronous inputs. The block has no streaming data path, so no valid/ready handshake applies: data moves as plain levels and the strobes are edge-qualified controls.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: While `rst_n` is low, every bit of `a_oe` and `b_oe` is 0. A clock edge with `rst_n` low clears both capture registers and both keepers of every lane to 0.
- R2: A lane whose `port_dis` bit is 1 drives neither bus: its bits of `a_oe` and `b_oe` are all 0.
- R3: With `port_dis`=0, the lane drives the A side when `dir_ab`=0 and the B side when `dir_ab`=1. It sets all of that side's `*_oe` bits to 1 and never enables both sides in the same cycle.
- R4: With `port_dis`=0, `dir_ab`=0 and `sel_ba`=0, `a_out` equals the lane's resolved B value in the same cycle. That value is `b_in` when `b_ext`=1 and the B keeper otherwise.
- R5: With `port_dis`=0, `dir_ab`=0 and `sel_ba`=1, `a_out` equals the lane's B capture register.
- R6: With `port_dis`=0, `dir_ab`=1 and `sel_ab`=0, `a_out`'s counterpart `b_out` equals the resolved A value in the same cycle.
- R7: With `port_dis`=0, `dir_ab`=1 and `sel_ab`=1, `b_out` equals the lane's A capture register.
- R8: When `cap_ab` is 1 in a cycle and was 0 in the cycle before, the A capture register loads that cycle's `a_bus` at the clock edge. The new value is visible from the next cycle, in every mode, including `port_dis`=1. Holding `cap_ab` high loads nothing more.
- R9: The same rule as R8 holds for `cap_ba`, the B capture register and `b_bus`.
- R10: While a bus side of a lane is driven neither by the lane nor from outside, its `*_bus` view holds the last value driven on it, across any number of cycles.
- R11: `a_bus` shows `a_out` while the lane drives A, `a_in` while only `a_ext` is 1, and the keeper otherwise. The B side follows the same rule. An outside driver has no effect on a side the lane drives.
- R12: Lanes are independent. Lane `i` uses control bit `i` and data bits `[i*CH_W +: CH_W]`, and no control of one lane changes another lane's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_dis | input | NUM_CH (2) | Per-lane isolate: 1 disables both bus drivers |
| dir_ab | input | NUM_CH (2) | Per-lane direction: 0 drives A, 1 drives B |
| sel_ab | input | NUM_CH (2) | B-side source: 0 live A, 1 stored A |
| sel_ba | input | NUM_CH (2) | A-side source: 0 live B, 1 stored B |
| cap_ab | input | NUM_CH (2) | A capture strobe, acts on its rising edge |
| cap_ba | input | NUM_CH (2) | B capture strobe, acts on its rising edge |
| a_in | input | NUM_CH*CH_W (16) | Value an outside driver puts on the A bus |
| a_ext | input | NUM_CH (2) | Per-lane flag: outside driver active on A |
| a_out | output | NUM_CH*CH_W (16) | Value the block drives on the A bus |
| a_oe | output | NUM_CH*CH_W (16) | Per-bit A output enable |
| a_bus | output | NUM_CH*CH_W (16) | Resolved A bus, keeper value when undriven |
| b_in | input | NUM_CH*CH_W (16) | Value an outside driver puts on the B bus |
| b_ext | input | NUM_CH (2) | Per-lane flag: outside driver active on B |
| b_out | output | NUM_CH*CH_W (16) | Value the block drives on the B bus |
| b_oe | output | NUM_CH*CH_W (16) | Per-bit B output enable |
| b_bus | output | NUM_CH*CH_W (16) | Resolved B bus, keeper value when undriven |

## Verification
The output enables, the live paths and the resolved views depend only on the current inputs and stored state, so they are due in the same cycle as the stimulus. Capture registers and keepers change at the clock edge that ends the stimulus cycle. Their effect is due one cycle later. The strobe-edge cycle still shows the old stored value, and the bench checks for it explicitly. The bench applies each stimulus just after a falling edge and samples 2 ns later, before the next rising edge. Each table row therefore states the combinational result of its own inputs on top of the state left by the earlier rows.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which side of a lane is driven this cycle.
  typedef enum logic [1:0] {
    PATH_ISO = 2'd0,
    PATH_B2A = 2'd1,
    PATH_A2B = 2'd2
  } path_e;

  // Reset, isolate and direction decide the drive path (R1, R2, R3).
  function automatic path_e path_of(input logic live, input logic dis, input logic a2b);
    if (!live || dis) return PATH_ISO;
    return a2b ? PATH_A2B : PATH_B2A;
  endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // One-cycle pulse on a 0-to-1 change of the sampled strobe (R8, R9).
  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         port_dis,
  input  logic         dir_ab,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] a_bus,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] b_bus
);
  path_e        path;
  logic         rise_ab, rise_ba;
  logic [W-1:0] a_reg, b_reg;
  logic [W-1:0] a_keep, b_keep;
  logic [W-1:0] a_far, b_far;

  assign path  = path_of(rst_n, port_dis, dir_ab);
  assign a_drv = (path == PATH_B2A);
  assign b_drv = (path == PATH_A2B);

  // What each bus shows when the lane itself is not driving it. Built
  // apart from the lane's own outputs so no combinational loop forms.
  assign a_far = a_ext ? a_in : a_keep;
  assign b_far = b_ext ? b_in : b_keep;

  // Source selects: live far side or stored copy (R4..R7).
  assign a_out = sel_ba ? b_reg : b_far;
  assign b_out = sel_ab ? a_reg : a_far;

  // Resolved views: the lane's own driver wins over an outside one (R11).
  assign a_bus = a_drv ? a_out : a_far;
  assign b_bus = b_drv ? b_out : b_far;

  xcvr_rise_det u_rise_ab (.clk(clk), .rst_n(rst_n), .lvl(cap_ab), .rise(rise_ab));
  xcvr_rise_det u_rise_ba (.clk(clk), .rst_n(rst_n), .lvl(cap_ba), .rise(rise_ba));

  // Capture registers load whatever the mode (R8, R9).
  xcvr_hold_reg #(.W(W)) u_areg (
    .clk(clk), .rst_n(rst_n), .load(rise_ab), .d(a_bus), .q(a_reg));
  xcvr_hold_reg #(.W(W)) u_breg (
    .clk(clk), .rst_n(rst_n), .load(rise_ba), .d(b_bus), .q(b_reg));

  // Keepers follow any active driver and hold otherwise (R10).
  xcvr_hold_reg #(.W(W)) u_akeep (
    .clk(clk), .rst_n(rst_n), .load(a_drv | a_ext), .d(a_bus), .q(a_keep));
  xcvr_hold_reg #(.W(W)) u_bkeep (
    .clk(clk), .rst_n(rst_n), .load(b_drv | b_ext), .d(b_bus), .q(b_keep));
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      port_dis,
  input  logic [NUM_CH-1:0]      dir_ab,
  input  logic [NUM_CH-1:0]      sel_ab,
  input  logic [NUM_CH-1:0]      sel_ba,
  input  logic [NUM_CH-1:0]      cap_ab,
  input  logic [NUM_CH-1:0]      cap_ba,
  input  logic [NUM_CH*CH_W-1:0] a_in,
  input  logic [NUM_CH-1:0]      a_ext,
  output logic [NUM_CH*CH_W-1:0] a_out,
  output logic [NUM_CH*CH_W-1:0] a_oe,
  output logic [NUM_CH*CH_W-1:0] a_bus,
  input  logic [NUM_CH*CH_W-1:0] b_in,
  input  logic [NUM_CH-1:0]      b_ext,
  output logic [NUM_CH*CH_W-1:0] b_out,
  output logic [NUM_CH*CH_W-1:0] b_oe,
  output logic [NUM_CH*CH_W-1:0] b_bus
);
  localparam int BUS_W = NUM_CH * CH_W;

  logic [NUM_CH-1:0] a_drv, b_drv;

  // One lane per control bit, owning a CH_W slice of each bus (R12).
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    localparam int LO = c * CH_W;

    xcvr_lane #(.W(CH_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_dis(port_dis[c]),
      .dir_ab  (dir_ab[c]),
      .sel_ab  (sel_ab[c]),
      .sel_ba  (sel_ba[c]),
      .cap_ab  (cap_ab[c]),
      .cap_ba  (cap_ba[c]),
      .a_in    (a_in[LO +: CH_W]),
      .a_ext   (a_ext[c]),
      .b_in    (b_in[LO +: CH_W]),
      .b_ext   (b_ext[c]),
      .a_out   (a_out[LO +: CH_W]),
      .a_drv   (a_drv[c]),
      .a_bus   (a_bus[LO +: CH_W]),
      .b_out   (b_out[LO +: CH_W]),
      .b_drv   (b_drv[c]),
      .b_bus   (b_bus[LO +: CH_W])
    );

    // Per-bit enables copy the lane's drive decision (R3).
    assign a_oe[LO +: CH_W] = {CH_W{a_drv[c]}};
    assign b_oe[LO +: CH_W] = {CH_W{b_drv[c]}};
  end

  if (BUS_W != NUM_CH * CH_W) begin : g_bad_width
    $error("bus width mismatch");
  end
endmodule

// File: rtl/bidir_reg_xcvr_chk.sv
module bidir_reg_xcvr_chk #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      port_dis,
  input logic [NUM_CH-1:0]      dir_ab,
  input logic [NUM_CH-1:0]      sel_ab,
  input logic [NUM_CH-1:0]      sel_ba,
  input logic [NUM_CH-1:0]      cap_ab,
  input logic [NUM_CH-1:0]      cap_ba,
  input logic [NUM_CH*CH_W-1:0] a_in,
  input logic [NUM_CH-1:0]      a_ext,
  input logic [NUM_CH*CH_W-1:0] a_out,
  input logic [NUM_CH*CH_W-1:0] a_oe,
  input logic [NUM_CH*CH_W-1:0] a_bus,
  input logic [NUM_CH*CH_W-1:0] b_in,
  input logic [NUM_CH-1:0]      b_ext,
  input logic [NUM_CH*CH_W-1:0] b_out,
  input logic [NUM_CH*CH_W-1:0] b_oe,
  input logic [NUM_CH*CH_W-1:0] b_bus
);
  // R1: no driver enabled while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int LO = c * CH_W;

    a_r2_isolation: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis[c] |-> (a_oe[LO +: CH_W] == '0 && b_oe[LO +: CH_W] == '0));

    a_r3_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !((|a_oe[LO +: CH_W]) && (|b_oe[LO +: CH_W])));

    a_r4_live_b2a: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_dis[c] && !dir_ab[c] && !sel_ba[c] && b_ext[c])
      |-> a_out[LO +: CH_W] == b_in[LO +: CH_W]);

    a_r6_live_a2b: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_dis[c] && dir_ab[c] && !sel_ab[c] && a_ext[c])
      |-> b_out[LO +: CH_W] == a_in[LO +: CH_W]);

    a_r8_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rst_n) && $rose(cap_ab[c])) ##1 (!port_dis[c] && dir_ab[c] && sel_ab[c]))
      |-> b_out[LO +: CH_W] == $past(a_bus[LO +: CH_W]));

    a_r9_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rst_n) && $rose(cap_ba[c])) ##1 (!port_dis[c] && !dir_ab[c] && sel_ba[c]))
      |-> a_out[LO +: CH_W] == $past(b_bus[LO +: CH_W]));

    a_r10_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!a_oe[LO] && !a_ext[c]) && !a_oe[LO] && !a_ext[c])
      |-> $stable(a_bus[LO +: CH_W]));

    a_r10_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!b_oe[LO] && !b_ext[c]) && !b_oe[LO] && !b_ext[c])
      |-> $stable(b_bus[LO +: CH_W]));
  end
endmodule

bind bidir_reg_xcvr bidir_reg_xcvr_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .dir_ab(dir_ab),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe), .a_bus(a_bus),
  .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe), .b_bus(b_bus)
);

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  port_dis, dir_ab, sel_ab, sel_ba, cap_ab, cap_ba, a_ext, b_ext;
  logic [15:0] a_in, b_in;
  logic [15:0] a_out, a_oe, a_bus, b_out, b_oe, b_bus;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bidir_reg_xcvr #(.NUM_CH(2), .CH_W(8)) i_bidir_reg_xcvr (
    .clk(clk), .rst_n(rst_n), .port_dis(port_dis), .dir_ab(dir_ab),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe), .a_bus(a_bus),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe), .b_bus(b_bus)
  );

  typedef struct packed {
    logic [1:0]  dis, dab, sab, sba, cab, cba, aext, bext;
    logic [15:0] ain, bin;
    logic [1:0]  eaoe, eboe;
    logic [15:0] eabus, ebbus;
    logic [3:0]  req;
  } vec_t;

  // Lane 0 in the low byte / bit 0, lane 1 in the high byte / bit 1.
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R2: lane 0 isolated, outside drivers visible on both views
    '{2'b11,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,2'b01,16'h0011,16'h0022,2'b00,2'b00,16'h0011,16'h0022,4'd2},
    // R8: both strobes rise while isolated, A=33 B=44 stored
    '{2'b11,2'b00,2'b00,2'b00,2'b01,2'b01,2'b01,2'b01,16'h0033,16'h0044,2'b00,2'b00,16'h0033,16'h0044,4'd8},
    // R10: nothing drives, strobes held high, views keep 33/44
    '{2'b11,2'b00,2'b00,2'b00,2'b01,2'b01,2'b00,2'b00,16'h0055,16'h0066,2'b00,2'b00,16'h0033,16'h0044,4'd10},
    // R5: stored B (44) onto A
    '{2'b10,2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,2'b01,16'h0000,16'h0077,2'b01,2'b00,16'h0044,16'h0077,4'd5},
    // R4: live B onto A
    '{2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,16'h0000,16'h0088,2'b01,2'b00,16'h0088,16'h0088,4'd4},
    // R7: stored A (33) onto B
    '{2'b10,2'b01,2'b01,2'b00,2'b00,2'b00,2'b01,2'b00,16'h0099,16'h0000,2'b00,2'b01,16'h0099,16'h0033,4'd7},
    // R11: live A onto B, outside B value 5A has no effect
    '{2'b10,2'b01,2'b00,2'b00,2'b00,2'b00,2'b01,2'b01,16'h00A5,16'h005A,2'b00,2'b01,16'h00A5,16'h00A5,4'd11},
    // R10: A undriven, keeper A5 feeds B live
    '{2'b10,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,16'h00FF,16'h0000,2'b00,2'b01,16'h00A5,16'h00A5,4'd10},
    // R8: strobe edge cycle still shows old stored A (33)
    '{2'b10,2'b01,2'b01,2'b00,2'b01,2'b00,2'b01,2'b00,16'h00C3,16'h0000,2'b00,2'b01,16'h00C3,16'h0033,4'd8},
    // R8: next cycle shows C3; strobe held high does not reload
    '{2'b10,2'b01,2'b01,2'b00,2'b01,2'b00,2'b00,2'b00,16'h0000,16'h0000,2'b00,2'b01,16'h00C3,16'h00C3,4'd8},
    // R12: lane 1 live B onto A, lane 0 idle keeps C3/C3
    '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,16'h0000,16'h3C00,2'b10,2'b00,16'h3CC3,16'h3CC3,4'd12},
    // R7: lane 1 stored A is still reset value 00
    '{2'b01,2'b10,2'b10,2'b00,2'b00,2'b00,2'b10,2'b00,16'h7E00,16'h0000,2'b00,2'b10,16'h7EC3,16'h00C3,4'd7},
    // R9: lane 1 B strobe rises while isolated, stores E1
    '{2'b11,2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,2'b10,16'h0000,16'hE100,2'b00,2'b00,16'h7EC3,16'hE1C3,4'd9},
    // R5: lane 1 stored B (E1) onto A, B keeper E1
    '{2'b01,2'b00,2'b00,2'b10,2'b00,2'b10,2'b00,2'b00,16'h0000,16'h0000,2'b10,2'b00,16'hE1C3,16'hE1C3,4'd5},
    // R10: both lanes idle, keepers persist through disable
    '{2'b11,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,16'h0000,16'h0000,2'b00,2'b00,16'hE1C3,16'hE1C3,4'd10},
    // R12: lane 0 stored B to A while lane 1 live A to B
    '{2'b00,2'b10,2'b00,2'b01,2'b00,2'b00,2'b10,2'b00,16'h5F00,16'h0000,2'b01,2'b10,16'h5F44,16'h5FC3,4'd12}
  };

  function automatic logic [15:0] expand(input logic [1:0] e);
    return {{8{e[1]}}, {8{e[0]}}};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    port_dis = 2'b11; dir_ab = '0; sel_ab = '0; sel_ba = '0;
    cap_ab = '0; cap_ba = '0; a_ext = '0; b_ext = '0; a_in = '0; b_in = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: state after reset, all views zero, nothing enabled
    check("R1", "a_oe", a_oe, 16'h0000);
    check("R1", "b_oe", b_oe, 16'h0000);
    check("R1", "a_bus", a_bus, 16'h0000);
    check("R1", "b_bus", b_bus, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      port_dis = v.dis; dir_ab = v.dab; sel_ab = v.sab; sel_ba = v.sba;
      cap_ab = v.cab; cap_ba = v.cba; a_ext = v.aext; b_ext = v.bext;
      a_in = v.ain; b_in = v.bin;
      #2;
      check($sformatf("R%0d", v.req), "oe", {a_oe[8], a_oe[0], b_oe[8], b_oe[0]},
            {12'h000, v.eaoe, v.eboe});
      check($sformatf("R%0d", v.req), "a_oe_bits", a_oe, expand(v.eaoe));
      check($sformatf("R%0d", v.req), "a_bus", a_bus, v.eabus);
      check($sformatf("R%0d", v.req), "b_bus", b_bus, v.ebbus);
    end

    // R1: reset while both lanes request a drive
    @(negedge clk);
    rst_n = 1'b0;
    port_dis = 2'b00; dir_ab = 2'b10;
    #2;
    check("R1", "a_oe in reset", a_oe, 16'h0000);
    check("R1", "b_oe in reset", b_oe, 16'h0000);
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1", "a_bus keeper cleared", a_bus, 16'h0000);
    check("R1", "b_bus keeper cleared", b_bus, 16'h0000);

    // R1 / R3: stored copies cleared; lane 0 drives A, lane 1 drives B
    @(negedge clk);
    port_dis = 2'b00; dir_ab = 2'b10; sel_ba = 2'b01; sel_ab = 2'b10;
    #2;
    check("R1", "stored values", {b_bus[15:8], a_bus[7:0]}, 16'h0000);
    check("R3", "a_oe lane 0", a_oe, 16'h00FF);
    check("R3", "b_oe lane 1", b_oe, 16'hFF00);

    // R8: capture of a value the lane itself drives onto A
    @(negedge clk);
    idle_inputs();
    port_dis = 2'b10; dir_ab = 2'b00; sel_ba = 2'b00;
    b_ext = 2'b01; b_in = 16'h0096; cap_ab = 2'b01;
    #2;
    check("R4", "a_bus live", a_bus[7:0], 16'h0096);
    @(negedge clk);
    cap_ab = 2'b00; b_ext = 2'b00; dir_ab = 2'b01; sel_ab = 2'b01;
    #2;
    check("R8", "b_bus stored driven A", b_bus[7:0], 16'h0096);
    check("R6", "lane 1 untouched b_bus", b_bus[15:8], 16'h0000);

    finish_run();
  end
endmodule